// File: doc/BRIEF.md
# I2C Bit-Rate Prescale Calculator

This block turns an engine clock frequency into the 16-bit prescale word that sets the bit rate of an I2C engine. The frequency arrives in units of 10 kHz together with a one-cycle start strobe. The block then computes the word over several cycles. When the word is ready, it raises a one-cycle done pulse. The prescale word and a saturation flag are registered and hold their values until the next result.

Three calculation styles are selectable. The search style first divides the scaled clock down to a target value. It then walks a loop index upward until the index squared exceeds that target, which gives a pair of split dividers packed into two bytes. The two closed-form styles perform a single division by a fixed constant and place the quotient into one byte of the word. All division is done by an iterative shift-subtract unit that produces one quotient bit per cycle.

Top module: `prescale_calc`

## Requirements
- R1: After reset, prescale_o is 0, done_o is 0 and sat_o is 0.
- R2: A start_i seen while a computation is running is ignored. The result and the number of done pulses match those of the first request only.
- R3: With mode_i = 0 (search), let t = floor(eclk_i*10/240). L is the smallest value from 1 to 254 for which t < L*L, which is the same as floor(t/L) < L. The output is prescale_o[15:8] = L-1 and prescale_o[7:0] = (L-2) mod 256.
- R4: In search mode, when t = 0, L = 1 and the word is 16'h00FF. When t = 1, L = 2 and the word is 16'h0100.
- R5: In search mode, if no L up to 254 satisfies the condition, L is taken as 255. The word is then 16'hFEFD and sat_o is 1. sat_o is 0 for every other result.
- R6: With mode_i = 1 or 3, prescale_o[15:8] = (floor(eclk_i*10/51200) + 1) mod 256 and prescale_o[7:0] = 8'h80.
- R7: With mode_i = 2, prescale_o = (32512 + floor(eclk_i*10/25400)) mod 65536. This places 127 in the high byte before the quotient is added.
- R8: done_o lasts exactly one cycle. prescale_o and sat_o change only in a cycle where done_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a computation (taken only when idle) |
| mode_i | input | 2 | 0 search, 1 and 3 fixed/128, 2 fixed/127 |
| eclk_i | input | CLK_W | Engine clock in 10 kHz units |
| prescale_o | output | 16 | Prescale word, held between results |
| done_o | output | 1 | One-cycle pulse when prescale_o is updated |
| sat_o | output | 1 | Search loop reached its limit |

## Verification
The hardest cases to reach are the exact edges of the search loop. These are the inputs where t sits one below or exactly on a perfect square, including t = 64515 against t = 64516, where saturation begins. Random clock values almost never land on them, so the bench computes eclk_i values that give chosen t values and mixes them in with the random ones. A second hard case is a start that arrives in the middle of a long search. The bench issues one several cycles into a run, then checks the result and watches for any stray second done pulse.

// File: rtl/prescale_pkg.sv
package prescale_pkg;
  typedef enum logic [1:0] {
    MODE_SEARCH   = 2'd0,
    MODE_FIX128   = 2'd1,
    MODE_FIX127   = 2'd2,
    MODE_FIX128_B = 2'd3
  } mode_e;

  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_DIV = 2'd1, ST_SRCH = 2'd2} calc_st_e;

  localparam int DIV_W       = 16;
  localparam int LOOP_MAX    = 255;
  localparam int ROOT_W      = 8;
  localparam int SEARCH_DEN  = 60 * 4;
  localparam int FIX128_DEN  = 4 * 128 * 100;
  localparam int FIX127_DEN  = 4 * 127 * 50;
  localparam int FIX127_BASE = 127 << 8;

  function automatic logic [DIV_W-1:0] mode_den(mode_e m);
    case (m)
      MODE_SEARCH: mode_den = DIV_W'(SEARCH_DEN);
      MODE_FIX127: mode_den = DIV_W'(FIX127_DEN);
      default:     mode_den = DIV_W'(FIX128_DEN);
    endcase
  endfunction
endpackage

// File: rtl/prescale_div.sv
module prescale_div #(
  parameter int DW = 28,
  parameter int VW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [DW-1:0] dividend_i,
  input  logic [VW-1:0] divisor_i,
  output logic [DW-1:0] quot_o,
  output logic          done_o
);
  localparam int CW = $clog2(DW + 1);

  logic [DW-1:0] sh_q;
  logic [VW-1:0] rem_q, dvs_q;
  logic [CW-1:0] cnt_q;
  logic          run_q;
  logic [VW:0]   trial, diff;
  logic          fit;

  // restoring step: shift in next dividend bit, subtract if it fits
  assign trial  = {rem_q, sh_q[DW-1]};
  assign fit    = trial >= {1'b0, dvs_q};
  assign diff   = trial - {1'b0, dvs_q};
  assign quot_o = sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      rem_q  <= '0;
      dvs_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        sh_q  <= dividend_i;
        rem_q <= '0;
        dvs_q <= divisor_i;
        cnt_q <= CW'(DW);
        run_q <= 1'b1;
      end else if (run_q) begin
        sh_q  <= {sh_q[DW-2:0], fit};
        rem_q <= fit ? diff[VW-1:0] : trial[VW-1:0];
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          run_q  <= 1'b0;
          done_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/prescale_search.sv
module prescale_search #(
  parameter int NW   = 28,
  parameter int LBW  = 8,
  parameter int LMAX = 255
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [NW-1:0]  nm_i,
  output logic [LBW-1:0] root_o,
  output logic           sat_o,
  output logic           done_o
);
  localparam int SW = 2 * LBW + 1;
  localparam int MW = (NW > SW) ? NW : SW;

  logic [LBW-1:0] l_q;
  logic [SW-1:0]  sq_q;
  logic [NW-1:0]  nm_q;
  logic           run_q;
  logic           hit;

  // nm / L < L  <=>  nm < L*L ; L*L kept incrementally
  assign hit = MW'(nm_q) < MW'(sq_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      l_q    <= '0;
      sq_q   <= '0;
      nm_q   <= '0;
      run_q  <= 1'b0;
      root_o <= '0;
      sat_o  <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        l_q   <= LBW'(1);
        sq_q  <= SW'(1);
        nm_q  <= nm_i;
        run_q <= 1'b1;
      end else if (run_q) begin
        if (hit) begin
          root_o <= l_q;
          sat_o  <= 1'b0;
          done_o <= 1'b1;
          run_q  <= 1'b0;
        end else if (l_q == LBW'(LMAX - 1)) begin
          root_o <= LBW'(LMAX);
          sat_o  <= 1'b1;
          done_o <= 1'b1;
          run_q  <= 1'b0;
        end else begin
          l_q  <= l_q + 1'b1;
          sq_q <= sq_q + {SW'(l_q), 1'b1};
        end
      end
    end
  end
endmodule

// File: rtl/prescale_calc.sv
module prescale_calc
  import prescale_pkg::*;
#(
  parameter int CLK_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [1:0]       mode_i,
  input  logic [CLK_W-1:0] eclk_i,
  output logic [15:0]      prescale_o,
  output logic             done_o,
  output logic             sat_o
);
  localparam int DW = CLK_W + 4;

  calc_st_e          st_q;
  mode_e             mode_q;
  logic              accept;
  logic [DW-1:0]     dividend, quot;
  logic              div_done, srch_start, srch_done, srch_sat;
  logic [ROOT_W-1:0] root;
  logic [15:0]       closed_word;

  assign accept     = start_i && (st_q == ST_IDLE);
  assign dividend   = ({4'b0, eclk_i} << 3) + ({4'b0, eclk_i} << 1);
  assign srch_start = div_done && (mode_q == MODE_SEARCH);
  assign closed_word = (mode_q == MODE_FIX127) ? 16'(FIX127_BASE) + quot[15:0]
                                               : {quot[7:0] + 8'd1, 8'h80};

  prescale_div #(.DW(DW), .VW(DIV_W)) u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (accept),
    .dividend_i (dividend),
    .divisor_i  (mode_den(mode_e'(mode_i))),
    .quot_o     (quot),
    .done_o     (div_done)
  );

  prescale_search #(.NW(DW), .LBW(ROOT_W), .LMAX(LOOP_MAX)) u_srch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (srch_start),
    .nm_i    (quot),
    .root_o  (root),
    .sat_o   (srch_sat),
    .done_o  (srch_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      mode_q     <= MODE_SEARCH;
      prescale_o <= '0;
      sat_o      <= 1'b0;
      done_o     <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (st_q)
        ST_IDLE: if (accept) begin
          mode_q <= mode_e'(mode_i);
          st_q   <= ST_DIV;
        end
        ST_DIV: if (div_done) begin
          if (mode_q == MODE_SEARCH) st_q <= ST_SRCH;
          else begin
            prescale_o <= closed_word;
            sat_o      <= 1'b0;
            done_o     <= 1'b1;
            st_q       <= ST_IDLE;
          end
        end
        ST_SRCH: if (srch_done) begin
          prescale_o <= {root - 8'd1, root - 8'd2};
          sat_o      <= srch_sat;
          done_o     <= 1'b1;
          st_q       <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/prescale_calc_chk.sv
module prescale_calc_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        done_o,
  input logic        sat_o,
  input logic [15:0] prescale_o,
  input logic [1:0]  mode_q
);
  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(prescale_o) && $stable(sat_o)));

  p_sat_code_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && sat_o) |-> (prescale_o == 16'hFEFD && mode_q == 2'd0));

  p_search_pack_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && mode_q == 2'd0) |-> (prescale_o[15:8] == prescale_o[7:0] + 8'd1));

  p_fixed_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && mode_q[0]) |-> (prescale_o[7:0] == 8'h80 && !sat_o));
endmodule

bind prescale_calc prescale_calc_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .done_o     (done_o),
  .sat_o      (sat_o),
  .prescale_o (prescale_o),
  .mode_q     (mode_q)
);

// File: tb/prescale_calc_test.sv
module prescale_calc_test;
  localparam int CLK_W = 24;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             start_i = 1'b0;
  logic [1:0]       mode_i = '0;
  logic [CLK_W-1:0] eclk_i = '0;
  logic [15:0]      prescale_o;
  logic             done_o, sat_o;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  prescale_calc #(.CLK_W(CLK_W)) uut (.*);

  always #5 clk_i = ~clk_i;

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: act %0d exp <150000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  function automatic logic [16:0] model(logic [1:0] m, logic [CLK_W-1:0] e);
    longint t, q;
    int l;
    if (m == 2'd0) begin
      t = (longint'(e) * 10) / 240;
      l = 255;
      for (int k = 1; k < 255; k++) if (t < longint'(k) * k) begin l = k; break; end
      return {l == 255, 8'(l - 1), 8'(l - 2)};
    end else if (m == 2'd2) begin
      q = (longint'(e) * 10) / 25400;
      return {1'b0, 16'(32512 + q)};
    end else begin
      q = (longint'(e) * 10) / 51200;
      return {1'b0, 8'(q + 1), 8'h80};
    end
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act %h exp %h", req, act, exp);
    end
  endtask

  task automatic wait_done(output bit seen);
    int t = 0;
    seen = 0;
    while (t < 1000) begin
      @(negedge clk_i);
      if (done_o) begin seen = 1; break; end
      t++;
    end
  endtask

  task automatic run(logic [1:0] m, logic [CLK_W-1:0] e, string req);
    bit seen;
    logic [16:0] exp = model(m, e);
    @(negedge clk_i);
    start_i = 1; mode_i = m; eclk_i = e;
    @(negedge clk_i);
    start_i = 0;
    wait_done(seen);
    chk(seen, {req, " done"}, 32'(seen), 1);
    chk({sat_o, prescale_o} == exp, req, {15'd0, sat_o, prescale_o}, {15'd0, exp});
    @(negedge clk_i);
    chk(!done_o && {sat_o, prescale_o} == exp, "R8 pulse/hold",
        {14'd0, done_o, sat_o, prescale_o}, {15'd0, exp});
  endtask

  initial begin
    bit seen;
    logic [16:0] exp;
    void'($urandom(32'd7719));
    repeat (3) @(negedge clk_i);
    chk(prescale_o == 0 && !done_o && !sat_o, "R1 reset",
        {14'd0, done_o, sat_o, prescale_o}, 0);
    rst_ni = 1;

    run(2'd0, 24'd0,  "R4 t=0");
    run(2'd0, 24'd23, "R4 t=0 upper");
    run(2'd0, 24'd24, "R4 t=1");
    run(2'd0, 24'd72, "R3 t=3");
    run(2'd0, 24'd96, "R3 t=4 square");
    run(2'd0, 24'd1548360, "R3 t=64515 edge");
    run(2'd0, 24'd1548384, "R5 t=64516 sat");
    run(2'd0, 24'hFFFFFF,  "R5 max sat");
    run(2'd1, 24'd0,       "R6 zero");
    run(2'd3, 24'hFFFFFF,  "R6 mode3 max");
    run(2'd1, 24'd5120,    "R6 exact");
    run(2'd2, 24'd0,       "R7 zero");
    run(2'd2, 24'hFFFFFF,  "R7 max");
    run(2'd2, 24'd2540,    "R7 exact");

    // R2: second start mid-search is ignored
    exp = model(2'd0, 24'd1000000);
    @(negedge clk_i);
    start_i = 1; mode_i = 2'd0; eclk_i = 24'd1000000;
    @(negedge clk_i);
    start_i = 0;
    repeat (40) @(negedge clk_i);
    start_i = 1; mode_i = 2'd2; eclk_i = 24'd77;
    @(negedge clk_i);
    start_i = 0;
    wait_done(seen);
    chk(seen && {sat_o, prescale_o} == exp, "R2 ignored start",
        {15'd0, sat_o, prescale_o}, {15'd0, exp});
    wait_done(seen);
    chk(!seen, "R2 no extra done", 32'(seen), 0);

    for (int i = 0; i < 60; i++) begin
      logic [1:0] m = 2'($urandom);
      logic [CLK_W-1:0] e = (i % 2) ? CLK_W'($urandom_range(0, 20000)) : CLK_W'($urandom);
      run(m, e, m == 2'd0 ? "R3 rand" : (m == 2'd2 ? "R7 rand" : "R6 rand"));
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule